// File: doc/BRIEF.md
# Clocked Serial Shift Transceiver

This block is a full-duplex synchronous serial port that moves one byte at a time. A single data register holds the outgoing and the incoming byte. Software writes a byte into it and raises the run control. On each falling serial clock edge the block drives one bit, least significant bit first. On each rising edge it takes in one bit. When the last bit has been taken in, the received byte replaces the register contents and a one-cycle interrupt pulse is raised.

The serial clock comes from one of two sources. With the internal clock, the block divides the system clock by an even ratio and drives the clock out. This clock idles high. After each byte it stays parked until the received byte has been read and a fresh byte has been written. With the external clock, a remote master drives the clock. The block synchronizes that clock into the system domain and follows its edges without waiting, so a byte that software has not serviced is simply shifted out again.

Two ways of stopping are offered. Dropping the run control lets the byte in progress finish and reach the register. Pulsing the abort input stops at once, and nothing is captured.

Top module: `sync_shift_xcvr`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o=0, irq_o=0, sclk_o=1, sdo_o=0 and rdata_o=0.
- R2: With ext_sel_i=0, sclk_o idles high and toggles every CLK_DIV/2 system cycles while shifting. sdo_o changes only with a falling sclk_o edge and carries the transmit byte least significant bit first. sdi_i is taken at each rising sclk_o edge, eight bits per byte.
- R3: At the eighth rising edge of a byte, rdata_o takes the received byte (first received bit in bit 0), and irq_o is high for exactly one cycle.
- R4: With ext_sel_i=0, once a byte has completed, sclk_o stays high until both a read strobe (rd_i) and a write strobe (wr_i) have been seen, in either order. Either strobe alone leaves the clock parked.
- R5: busy_o rises in the cycle after run_i is sampled high while idle, and it stays high during the wait between bytes. With run_i low and busy_o low, busy_o stays low.
- R6: From the rise of busy_o, or from the end of the previous byte, until the first falling edge of the next byte, sdo_o keeps the last bit driven (0 after reset).
- R7: If run_i is dropped while a byte is in progress, the byte completes, is captured and raises irq_o with busy_o still high. busy_o falls one cycle later, and no further clock edges follow even if the register is serviced.
- R8: A one-cycle abort_i pulse makes busy_o low and sclk_o high in the next cycle. The partial byte is discarded: no irq_o, and rdata_o is unchanged.
- R9: With ext_sel_i=1, sclk_o stays high and shifting follows the synchronized edges of sclk_i without any wait. An unserviced register is shifted out as the next transmit byte.
- R10: A write strobe in the cycle where a byte is captured is discarded. rdata_o shows the captured byte, and the write does not count as servicing for R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run control; 1 = transfer enabled, 0 = stop after the current byte |
| abort_i | input | 1 | Immediate stop pulse |
| ext_sel_i | input | 1 | Clock source: 0 = internal divider, 1 = external sclk_i |
| wr_i | input | 1 | Data register write strobe |
| wdata_i | input | DATA_W | Byte to transmit |
| rd_i | input | 1 | Data register read strobe (marks received byte as taken) |
| rdata_o | output | DATA_W | Data register contents |
| busy_o | output | 1 | Transfer active flag |
| irq_o | output | 1 | One-cycle pulse per captured byte |
| sclk_o | output | 1 | Internal serial clock output, idles high |
| sclk_i | input | 1 | External serial clock input |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
The capture of a received byte into the shared register can coincide with a software write strobe, because both update that register in the same cycle. The bench counts falling edges of sclk_o to find the eighth falling edge. It waits the rest of that half period and then places the write strobe exactly on the capture edge. The result is judged on two points: rdata_o must show the received byte, and after only a read strobe the clock must stay parked, which proves the colliding write was not taken as service.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

   // single-cycle serial clock events in the system clock domain
   typedef struct packed {
      logic fall;
      logic rise;
   } sxc_edge_t;

endpackage

// File: rtl/sxc_clkgen.sv
module sxc_clkgen
   import sxc_pkg::*;
#(
   parameter int CLK_DIV     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ext_sel_i,
   input  logic      en_i,
   input  logic      kill_i,
   input  logic      sclk_ext_i,
   output logic      sclk_o,
   output sxc_edge_t edge_o
);

   localparam int HALF = CLK_DIV / 2;

   logic run_int;
   logic run_ext;
   logic tick;
   logic sclk_q;

   assign run_int = en_i && !kill_i && !ext_sel_i;
   assign run_ext = en_i && !kill_i && ext_sel_i;

   // divider variant picked by the ratio
   generate
      if (HALF == 1) begin : g_fast
         assign tick = run_int;
      end else begin : g_div
         localparam int CW = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_int || cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end

         assign tick = run_int && (cnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
      end else if (!run_int) begin
         sclk_q <= 1'b1;
      end else if (tick) begin
         sclk_q <= ~sclk_q;
      end
   end

   // external clock synchronizer and edge detector
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_ext_i};
         prev_q <= sync_out;
      end
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   always_comb begin
      if (ext_sel_i) begin
         edge_o.fall = run_ext && prev_q && !sync_out;
         edge_o.rise = run_ext && !prev_q && sync_out;
      end else begin
         edge_o.fall = tick && sclk_q;
         edge_o.rise = tick && !sclk_q;
      end
   end

   assign sclk_o = ext_sel_i ? 1'b1 : sclk_q;

endmodule

// File: rtl/sxc_shifter.sv
module sxc_shifter
   import sxc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sxc_edge_t         edge_i,
   input  logic              kill_i,
   input  logic [DATA_W-1:0] load_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              inbyte_o,
   output logic              first_o,
   output logic              cap_o,
   output logic [DATA_W-1:0] rx_word_o
);

   localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic [BW-1:0]     bit_q;
   logic              inbyte_q;
   logic              sdo_q;

   assign first_o   = edge_i.fall && !inbyte_q;
   assign cap_o     = edge_i.rise && inbyte_q && (bit_q == LASTBIT);
   assign rx_word_o = {sdi_i, rx_q[DATA_W-1:1]};
   assign sdo_o     = sdo_q;
   assign inbyte_o  = inbyte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q     <= '0;
         rx_q     <= '0;
         bit_q    <= '0;
         inbyte_q <= 1'b0;
         sdo_q    <= 1'b0;
      end else if (kill_i) begin
         bit_q    <= '0;
         inbyte_q <= 1'b0;
      end else begin
         if (edge_i.fall) begin
            if (!inbyte_q) begin
               tx_q     <= load_i;
               sdo_q    <= load_i[0];
               inbyte_q <= 1'b1;
            end else begin
               sdo_q <= tx_q[bit_q];
            end
         end
         if (edge_i.rise && inbyte_q) begin
            rx_q <= rx_word_o;
            if (bit_q == LASTBIT) begin
               bit_q    <= '0;
               inbyte_q <= 1'b0;
            end else begin
               bit_q <= bit_q + BW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/sxc_ctrl.sv
module sxc_ctrl #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              abort_i,
   input  logic              ext_sel_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_i,
   input  logic              inbyte_i,
   input  logic              first_i,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] rx_word_i,
   output logic [DATA_W-1:0] dreg_o,
   output logic              busy_o,
   output logic              irq_o,
   output logic              en_o
);

   logic [DATA_W-1:0] dreg_q;
   logic              loaded_q;
   logic              pend_q;
   logic              busy_q;
   logic              irq_q;
   logic              serviced;

   // internal clock may only begin a byte once the register is serviced
   assign serviced = ext_sel_i || (loaded_q && !pend_q);
   assign en_o     = busy_q && !abort_i && (inbyte_i || (run_i && serviced));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dreg_q   <= '0;
         loaded_q <= 1'b0;
         pend_q   <= 1'b0;
         busy_q   <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q  <= cap_i;
         busy_q <= !abort_i && (run_i || inbyte_i);

         // captured byte outranks a write in the same cycle
         if (cap_i) begin
            dreg_q <= rx_word_i;
         end else if (wr_i) begin
            dreg_q <= wdata_i;
         end

         if (cap_i) begin
            loaded_q <= loaded_q;
         end else if (wr_i) begin
            loaded_q <= 1'b1;
         end else if (first_i) begin
            loaded_q <= 1'b0;
         end

         if (cap_i) begin
            pend_q <= 1'b1;
         end else if (rd_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign dreg_o = dreg_q;
   assign busy_o = busy_q;
   assign irq_o  = irq_q;

endmodule

// File: rtl/sync_shift_xcvr.sv
module sync_shift_xcvr
   import sxc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_DIV     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              abort_i,
   input  logic              ext_sel_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              busy_o,
   output logic              irq_o,
   output logic              sclk_o,
   input  logic              sclk_i,
   input  logic              sdi_i,
   output logic              sdo_o
);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("sync_shift_xcvr: CLK_DIV must be even and at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("sync_shift_xcvr: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sync_shift_xcvr: SYNC_STAGES must be at least 2");
      end
   endgenerate

   sxc_edge_t         edges;
   logic              en;
   logic              inbyte;
   logic              first;
   logic              cap;
   logic [DATA_W-1:0] rx_word;
   logic [DATA_W-1:0] dreg;

   sxc_clkgen #(
      .CLK_DIV     (CLK_DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) clkgen_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_sel_i  (ext_sel_i),
      .en_i       (en),
      .kill_i     (abort_i),
      .sclk_ext_i (sclk_i),
      .sclk_o     (sclk_o),
      .edge_o     (edges)
   );

   sxc_shifter #(
      .DATA_W (DATA_W)
   ) shifter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_i    (edges),
      .kill_i    (abort_i),
      .load_i    (dreg),
      .sdi_i     (sdi_i),
      .sdo_o     (sdo_o),
      .inbyte_o  (inbyte),
      .first_o   (first),
      .cap_o     (cap),
      .rx_word_o (rx_word)
   );

   sxc_ctrl #(
      .DATA_W (DATA_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_i),
      .abort_i   (abort_i),
      .ext_sel_i (ext_sel_i),
      .wr_i      (wr_i),
      .wdata_i   (wdata_i),
      .rd_i      (rd_i),
      .inbyte_i  (inbyte),
      .first_i   (first),
      .cap_i     (cap),
      .rx_word_i (rx_word),
      .dreg_o    (dreg),
      .busy_o    (busy_o),
      .irq_o     (irq_o),
      .en_o      (en)
   );

   assign rdata_o = dreg;

endmodule

// File: rtl/sxc_chk.sv
module sxc_chk (
   input logic clk,
   input logic rst_n,
   input logic run_i,
   input logic abort_i,
   input logic ext_sel_i,
   input logic busy_o,
   input logic irq_o,
   input logic sclk_o,
   input logic sdo_o
);

   // R3
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R8
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!busy_o && sclk_o));

   // R2
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> sclk_o);

   // R9
   ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_sel_i |-> sclk_o);

   // R6
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_sel_i && !$fell(sclk_o)) |-> $stable(sdo_o));

   // R5
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !run_i) |=> !busy_o);

   // R4
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ext_sel_i) |=> sclk_o);

endmodule

bind sync_shift_xcvr sxc_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_i     (run_i),
   .abort_i   (abort_i),
   .ext_sel_i (ext_sel_i),
   .busy_o    (busy_o),
   .irq_o     (irq_o),
   .sclk_o    (sclk_o),
   .sdo_o     (sdo_o)
);

// File: tb/sync_shift_xcvr_tb_top.sv
`timescale 1ns/1ps
module sync_shift_xcvr_tb_top;

   localparam int DW  = 8;
   localparam int DIV = 4;

   // {service order (0 = read first, 1 = write first), tx byte, peer byte}
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 8'hA5, 8'h3C},
      {1'b1, 8'h01, 8'hFF},
      {1'b0, 8'h80, 8'h00},
      {1'b1, 8'h7E, 8'h81},
      {1'b0, 8'hFF, 8'h5A},
      {1'b1, 8'h00, 8'hC3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_i = 1'b0;
   logic          abort_i = 1'b0;
   logic          ext_sel_i = 1'b0;
   logic          wr_i = 1'b0;
   logic [DW-1:0] wdata_i = '0;
   logic          rd_i = 1'b0;
   logic [DW-1:0] rdata_o;
   logic          busy_o;
   logic          irq_o;
   logic          sclk_o;
   logic          sclk_i = 1'b1;
   logic          sdi_i;
   logic          sdo_o;

   logic          sdi_int = 1'b0;
   logic          sdi_ext = 1'b0;
   logic          ext_tb = 1'b0;

   assign sdi_i = ext_tb ? sdi_ext : sdi_int;

   always #4 clk = ~clk;

   sync_shift_xcvr #(
      .DATA_W      (DW),
      .CLK_DIV     (DIV),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_i),
      .abort_i   (abort_i),
      .ext_sel_i (ext_sel_i),
      .wr_i      (wr_i),
      .wdata_i   (wdata_i),
      .rd_i      (rd_i),
      .rdata_o   (rdata_o),
      .busy_o    (busy_o),
      .irq_o     (irq_o),
      .sclk_o    (sclk_o),
      .sclk_i    (sclk_i),
      .sdi_i     (sdi_i),
      .sdo_o     (sdo_o)
   );

   int total = 0;
   int bad = 0;

   // peer model for the internal clock: drives on falls, samples on rises
   int            fall_cnt = 0;
   int            irq_cnt = 0;
   int            cyc = 0;
   int            last_fall = 0;
   int            fall_gap = 0;
   logic          sclk_prev = 1'b1;
   logic [2:0]    pbit = '0;
   logic [DW-1:0] cap_word = '0;
   logic [DW-1:0] peer_byte = '0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (sclk_prev && !sclk_o) begin
            fall_cnt  = fall_cnt + 1;
            fall_gap  = cyc - last_fall;
            last_fall = cyc;
            sdi_int   = peer_byte[pbit];
         end
         if (!sclk_prev && sclk_o) begin
            cap_word[pbit] = sdo_o;
            pbit = pbit + 3'd1;
         end
         if (irq_o) irq_cnt = irq_cnt + 1;
      end
      sclk_prev = sclk_o;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [DW-1:0] d);
      wdata_i = d;
      wr_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   task automatic do_rd();
      rd_i = 1'b1;
      @(negedge clk);
      rd_i = 1'b0;
   endtask

   task automatic ext_byte(input logic [DW-1:0] p, output logic [DW-1:0] got);
      for (int b = 0; b < DW; b++) begin
         sclk_i  = 1'b0;
         sdi_ext = p[b];
         repeat (4) @(negedge clk);
         got[b] = sdo_o;
         sclk_i = 1'b1;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int            exp_irq;
      int            f0;
      logic [DW-1:0] got;
      exp_irq = 0;

      // reset state
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", busy_o, 0);
      chk("R1 sclk in reset", sclk_o, 1);
      chk("R1 irq in reset", irq_o, 0);
      chk("R1 rdata in reset", rdata_o, 0);
      chk("R1 sdo in reset", sdo_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", busy_o, 0);
      chk("R1 sclk after reset", sclk_o, 1);

      // table walk, internal clock
      peer_byte = VEC[0][7:0];
      do_wr(VEC[0][15:8]);
      run_i = 1'b1;
      @(negedge clk);
      chk("R5 busy rises", busy_o, 1);
      chk("R6 sdo before first fall", sdo_o, 0);

      for (int i = 0; i < 6; i++) begin
         exp_irq = exp_irq + 1;
         wait (irq_cnt == exp_irq);
         chk("R3 rdata captured", rdata_o, VEC[i][7:0]);
         chk("R2 tx bits lsb first", cap_word, VEC[i][15:8]);
         chk("R2 sclk period", fall_gap, DIV);
         chk("R5 busy in wait state", busy_o, 1);
         if (i < 5) begin
            @(negedge clk);
            f0 = fall_cnt;
            peer_byte = VEC[i+1][7:0];
            if (VEC[i][16] == 1'b0) do_rd();
            else do_wr(VEC[i+1][15:8]);
            repeat (16) @(negedge clk);
            chk("R4 parked after one strobe", fall_cnt, f0);
            chk("R4 sclk high while parked", sclk_o, 1);
            if (VEC[i][16] == 1'b0) do_wr(VEC[i+1][15:8]);
            else do_rd();
            chk("R6 sdo holds last bit", sdo_o, VEC[i][15]);
            chk("R4 no fall before start", fall_cnt, f0);
         end
      end

      // graceful stop
      @(negedge clk);
      f0 = fall_cnt;
      peer_byte = 8'h96;
      do_rd();
      do_wr(8'h4B);
      wait (fall_cnt == f0 + 3);
      run_i = 1'b0;
      exp_irq = exp_irq + 1;
      wait (irq_cnt == exp_irq);
      chk("R7 byte completes", rdata_o, 8'h96);
      chk("R7 tx completes", cap_word, 8'h4B);
      chk("R7 busy at capture", busy_o, 1);
      @(negedge clk);
      chk("R7 busy falls", busy_o, 0);
      f0 = fall_cnt;
      do_rd();
      do_wr(8'h11);
      repeat (20) @(negedge clk);
      chk("R7 no clock after stop", fall_cnt, f0);
      chk("R7 busy stays low", busy_o, 0);

      // abort
      f0 = fall_cnt;
      peer_byte = 8'hE7;
      run_i = 1'b1;
      wait (fall_cnt == f0 + 3);
      @(negedge clk);
      abort_i = 1'b1;
      run_i = 1'b0;
      @(negedge clk);
      abort_i = 1'b0;
      chk("R8 busy cleared", busy_o, 0);
      chk("R8 sclk high", sclk_o, 1);
      f0 = fall_cnt;
      repeat (30) @(negedge clk);
      chk("R8 no irq", irq_cnt, exp_irq);
      chk("R8 no more clock", fall_cnt, f0);
      chk("R8 rdata unchanged", rdata_o, 8'h11);
      pbit = '0;

      // write colliding with capture
      do_wr(8'h3A);
      peer_byte = 8'h6D;
      f0 = fall_cnt;
      run_i = 1'b1;
      wait (fall_cnt == f0 + 8);
      repeat (DIV/2 - 1) @(negedge clk);
      wdata_i = 8'hF0;
      wr_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0;
      exp_irq = exp_irq + 1;
      wait (irq_cnt == exp_irq);
      chk("R10 capture wins", rdata_o, 8'h6D);
      chk("R2 tx of collided byte", cap_word, 8'h3A);
      @(negedge clk);
      f0 = fall_cnt;
      do_rd();
      repeat (20) @(negedge clk);
      chk("R10 discarded write is no service", fall_cnt, f0);
      chk("R10 rdata keeps captured", rdata_o, 8'h6D);
      peer_byte = 8'h2B;
      do_wr(8'h55);
      exp_irq = exp_irq + 1;
      wait (irq_cnt == exp_irq);
      chk("R3 resume after service", rdata_o, 8'h2B);
      chk("R2 resume tx", cap_word, 8'h55);
      run_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 idle before mode change", busy_o, 0);

      // external clock
      do_rd();
      do_wr(8'hC9);
      ext_tb = 1'b1;
      ext_sel_i = 1'b1;
      run_i = 1'b1;
      repeat (3) @(negedge clk);
      ext_byte(8'h1E, got);
      repeat (6) @(negedge clk);
      exp_irq = exp_irq + 1;
      chk("R9 ext irq", irq_cnt, exp_irq);
      chk("R9 ext rx", rdata_o, 8'h1E);
      chk("R9 ext tx", got, 8'hC9);
      chk("R9 sclk_o quiet", sclk_o, 1);
      ext_byte(8'hD2, got);
      repeat (6) @(negedge clk);
      exp_irq = exp_irq + 1;
      chk("R9 second byte without service", irq_cnt, exp_irq);
      chk("R9 second rx", rdata_o, 8'hD2);
      chk("R9 unserviced byte resent", got, 8'h1E);
      run_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 busy low after run off", busy_o, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule